// File: doc/BRIEF.md
# Interval Tick Timer

This block is a per-core interval tick timer. A clock prescaler produces one tick every (divider + 1) input clocks. Each tick decrements an interrupt counter. When that counter expires, the block sets an interrupt status bit. In auto-reload mode the counter refills from its buffer and keeps firing until software stops it. In single-shot mode it fires once and then waits for a restart.

Software drives the block through a small 32-bit register window with a byte offset. Every write to the divider, to the count buffer or to control is acknowledged by a sticky write-status bit, and software clears that bit by writing one to it. The interrupt output is the status bit gated by an enable bit.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero, both counters are stopped and `irq_o` is low.
- R2: With divider value D at offset 0x00 and count buffer N at offset 0x08, the status bit sets exactly N*(D+1) clock edges after the edge that commits a control write starting both counters. A count of 0 behaves as 1.
- R3: With control bit 2 set (auto-reload), the counter refills after each expiry and the status sets again every N*(D+1) edges. If a status clear and a new expiry land on the same edge, the status stays set.
- R4: With control bit 2 clear (single-shot), the counter expires once and raises no further expiry until it is restarted.
- R5: A write to offset 0x08 loads its low 31 bits into the count buffer only when data bit 31 is one; otherwise the buffer is unchanged. Reading offset 0x08 returns the buffer, with bit 31 reading zero.
- R6: Write-status at offset 0x40 sets bit 0 on a write to 0x00, bit 1 on any write to 0x08 and bit 3 on a write to 0x20, visible after the write's edge. Writing ones to 0x40 clears those bits and leaves the other bits unchanged.
- R7: Status bit 0 at offset 0x30 is cleared by writing one to it; writing zero has no effect. `irq_o` equals status AND enable bit 0 at offset 0x34, and the status reads one even while the enable is zero.
- R8: Clearing control bits 0 (tick run) and 1 (count run) halts both counters, so no expiry occurs. Setting them again counts a full N*(D+1) period from the buffer values.
- R9: Control at offset 0x20 reads back bits [2:0] as written; all its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Interrupt output |

## Verification
The timing path is swept over every divider value from 0 to 3 and every count from 1 to 4, once in auto-reload mode and once in single-shot mode, with a count of 0 added. Each run measures the exact edge of the first expiry, which separates an off-by-one in the prescaler from one in the interrupt counter. In auto-reload mode the run also measures the gap to the second expiry; the single-cycle period case shows that a set wins over a clear on the same edge. In single-shot mode the run watches a long quiet window after the expiry to expose an unwanted reload. Directed cases cover buffer loads with and without the load bit, write-status set and clear patterns, interrupt masking, and a stop in mid-period followed by a restart that must count a full period.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h40;

  localparam int unsigned ACK_DIV  = 0;
  localparam int unsigned ACK_CNT  = 1;
  localparam int unsigned ACK_CTRL = 3;
  localparam int unsigned ACK_W    = 4;

  typedef struct packed {
    logic auto_rl;  // bit 2
    logic cnt_go;   // bit 1
    logic tick_go;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/tick_regfile.sv
module tick_regfile
  import tick_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned DIV_W = 32,
  parameter int unsigned CNT_W = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              set_stat_i,
  output logic [DIV_W-1:0]  div_o,
  output logic [CNT_W-1:0]  cnt_buf_o,
  output ctrl_t             ctrl_o,
  output logic              irq_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cbuf_q, cbuf_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic             en_q, en_d;
  logic             stat_q, stat_d;
  logic [ACK_W-1:0] ack_q, ack_d;

  logic wr_div, wr_cnt, wr_ctrl, wr_stat, wr_en, wr_ack;
  assign wr_div  = we_i && (addr_i == OFS_DIV);
  assign wr_cnt  = we_i && (addr_i == OFS_CNT);
  assign wr_ctrl = we_i && (addr_i == OFS_CTRL);
  assign wr_stat = we_i && (addr_i == OFS_STAT);
  assign wr_en   = we_i && (addr_i == OFS_EN);
  assign wr_ack  = we_i && (addr_i == OFS_ACK);

  always_comb begin
    div_d  = div_q;
    cbuf_d = cbuf_q;
    ctrl_d = ctrl_q;
    en_d   = en_q;
    stat_d = stat_q;
    ack_d  = ack_q;
    if (wr_div)  div_d = wdata_i[DIV_W-1:0];
    if (wr_cnt && wdata_i[BUS_W-1]) cbuf_d = wdata_i[CNT_W-1:0];
    if (wr_ctrl) ctrl_d = ctrl_t'(wdata_i[CTRL_W-1:0]);
    if (wr_en)   en_d = wdata_i[0];
    if (wr_stat && wdata_i[0]) stat_d = 1'b0;
    if (set_stat_i) stat_d = 1'b1;
    if (wr_ack)  ack_d = ack_q & ~wdata_i[ACK_W-1:0];
    if (wr_div)  ack_d[ACK_DIV]  = 1'b1;
    if (wr_cnt)  ack_d[ACK_CNT]  = 1'b1;
    if (wr_ctrl) ack_d[ACK_CTRL] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cbuf_q <= '0;
      ctrl_q <= '0;
      en_q   <= 1'b0;
      stat_q <= 1'b0;
      ack_q  <= '0;
    end else begin
      div_q  <= div_d;
      cbuf_q <= cbuf_d;
      ctrl_q <= ctrl_d;
      en_q   <= en_d;
      stat_q <= stat_d;
      ack_q  <= ack_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_DIV:  rdata_o[DIV_W-1:0]  = div_q;
      OFS_CNT:  rdata_o[CNT_W-1:0]  = cbuf_q;
      OFS_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      OFS_STAT: rdata_o[0]          = stat_q;
      OFS_EN:   rdata_o[0]          = en_q;
      OFS_ACK:  rdata_o[ACK_W-1:0]  = ack_q;
      default:  rdata_o = '0;
    endcase
  end

  assign div_o     = div_q;
  assign cnt_buf_o = cbuf_q;
  assign ctrl_o    = ctrl_q;
  assign irq_o     = stat_q & en_q;

  assert_ack_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> ack_q[ACK_DIV]);
  assert_ack_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ack_q[ACK_CTRL]);
  assert_stat_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_stat_i |=> stat_q);
  assert_noload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !wdata_i[BUS_W-1]) |=> $stable(cbuf_q));
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pc_q, pc_d;

  assign tick_o = run_i && (pc_q >= div_i);

  always_comb begin
    if (!run_i || tick_o) pc_d = '0;
    else                  pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pc_q == '0));
endmodule

// File: rtl/tick_intcnt.sv
module tick_intcnt #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             auto_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] ic_q, ic_d;
  logic             done_q, done_d;
  logic             last;

  assign last     = (ic_q <= CNT_W'(1));
  assign expire_o = run_i && tick_i && !done_q && last;

  always_comb begin
    ic_d   = ic_q;
    done_d = done_q;
    if (!run_i) begin
      ic_d   = reload_i;
      done_d = 1'b0;
    end else if (tick_i && !done_q) begin
      if (last) begin
        if (auto_i) ic_d = reload_i;
        else        done_d = 1'b1;
      end else begin
        ic_d = ic_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q   <= '0;
      done_q <= 1'b0;
    end else begin
      ic_q   <= ic_d;
      done_q <= done_d;
    end
  end

  assert_single_shot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !auto_i) |=> !expire_o);
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && auto_i) |=> (ic_q == $past(reload_i)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned DIV_W = 32,
  parameter int unsigned CNT_W = BUS_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [DIV_W-1:0] div_val;
  logic [CNT_W-1:0] cnt_buf;
  ctrl_t            ctrl;
  logic             tick, expire;

  tick_regfile #(.BUS_W(BUS_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .set_stat_i(expire),
    .div_o(div_val), .cnt_buf_o(cnt_buf), .ctrl_o(ctrl), .irq_o(irq_o)
  );

  tick_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl.tick_go), .div_i(div_val),
    .tick_o(tick)
  );

  tick_intcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl.tick_go && ctrl.cnt_go),
    .auto_i(ctrl.auto_rl), .tick_i(tick), .reload_i(cnt_buf),
    .expire_o(expire)
  );

  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.cnt_go |-> !expire);
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called just after a negedge; write commits at the next posedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(output int cnt);
    cnt = 0;
    while (!irq_o && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic run_case(input int d, input int n, input bit auto_rl);
    int p, cnt;
    logic [31:0] v;
    p = ((n == 0) ? 1 : n) * (d + 1);
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h00, d);
    wr(8'h08, 32'h8000_0000 | n);
    wr(8'h34, 32'h1);
    wr(8'h20, {29'b0, auto_rl, 2'b11});
    wait_irq(cnt);
    chk($sformatf("R2 first expiry D=%0d N=%0d", d, n), cnt, p);
    if (auto_rl) begin
      wr(8'h30, 32'h1);
      wait_irq(cnt);
      chk($sformatf("R3 reload gap D=%0d N=%0d", d, n), cnt, p - 1);
    end else begin
      wr(8'h30, 32'h1);
      repeat (3 * p + 2) @(negedge clk);
      rd(8'h30, v);
      chk($sformatf("R4 no second expiry D=%0d N=%0d", d, n), {v[31:1], v[0] | irq_o}, 32'h0);
    end
  endtask

  initial begin
    logic [31:0] v;
    int cnt;
    logic [7:0] offs [6] = '{8'h00, 8'h08, 8'h20, 8'h30, 8'h34, 8'h40};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    foreach (offs[i]) begin
      rd(offs[i], v);
      chk($sformatf("R1 reset read ofs %0h", offs[i]), v, 32'h0);
    end
    chk("R1 irq low after reset", {31'b0, irq_o}, 32'h0);
    @(negedge clk);

    // R5 buffer load qualifier, R6 write status
    wr(8'h08, 32'h8000_0005);
    rd(8'h08, v); chk("R5 load with bit31", v, 32'h5);
    wr(8'h08, 32'h0000_0009);
    rd(8'h08, v); chk("R5 no load without bit31", v, 32'h5);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R5 readback bit31 zero", v, 32'h7FFF_FFFF);
    wr(8'h40, 32'hF);
    rd(8'h40, v); chk("R6 all cleared", v, 32'h0);
    wr(8'h00, 32'h3);
    rd(8'h40, v); chk("R6 divider ack", v, 32'h1);
    wr(8'h08, 32'h0000_0001);
    rd(8'h40, v); chk("R6 count ack without load", v, 32'h3);
    wr(8'h20, 32'hFFFF_FFFC);
    rd(8'h40, v); chk("R6 control ack", v, 32'hB);
    rd(8'h20, v); chk("R9 control readback", v, 32'h4);
    wr(8'h40, 32'h2);
    rd(8'h40, v); chk("R6 selective clear", v, 32'h9);

    // R2/R3/R4 sweep
    for (int d = 0; d < 4; d++)
      for (int n = 1; n < 5; n++)
        for (int m = 0; m < 2; m++)
          run_case(d, n, m[0]);
    run_case(2, 0, 1'b0);

    // R7 masking and status clear
    wr(8'h20, 32'h0);
    wr(8'h30, 32'h1);
    wr(8'h34, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h8000_0002);
    wr(8'h20, 32'h3);
    repeat (10) @(negedge clk);
    chk("R7 irq masked", {31'b0, irq_o}, 32'h0);
    rd(8'h30, v); chk("R7 status set while masked", v, 32'h1);
    wr(8'h34, 32'h1);
    chk("R7 irq after enable", {31'b0, irq_o}, 32'h1);
    wr(8'h30, 32'h0);
    rd(8'h30, v); chk("R7 write zero keeps status", v, 32'h1);
    wr(8'h30, 32'h1);
    rd(8'h30, v); chk("R7 status cleared", v, 32'h0);
    chk("R7 irq low after clear", {31'b0, irq_o}, 32'h0);

    // R8 stop mid-period, then full restart
    wr(8'h20, 32'h0);
    wr(8'h00, 32'h1);
    wr(8'h08, 32'h8000_0003);
    wr(8'h20, 32'h3);
    repeat (4) @(negedge clk);
    wr(8'h20, 32'h0);
    repeat (20) @(negedge clk);
    rd(8'h30, v); chk("R8 halted no expiry", {v[31:1], v[0] | irq_o}, 32'h0);
    wr(8'h20, 32'h3);
    wait_irq(cnt);
    chk("R8 restart full period", cnt, 6);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule